// File: doc/BRIEF.md
# Two-Channel DAC Input Latch Front End

This block is the digital front end of a two-channel digital-to-analog converter. It takes parallel straight-binary sample words, holds them in a pair of input latches and moves them into a pair of DAC latches whose contents drive the converter cores. Each output code comes with its complement, which is the share of full scale left for the opposite current output. All strobes are sampled on a fast system clock, and each action fires on a rising edge seen on a strobe.

A mode input chooses between two ways of working. In dual mode the two channels are fully independent. Each has its own data port, write strobe and update clock. In interleaved mode a single data port carries both channels. A select line steers each written word into one of the two input latches. A divide-by-two stage, driven by the interleaved clock, then moves both input latches into the DAC latches on the same edge. A divider reset input fixes which interleaved clock edge performs that move.

Top module: `dac_front`

## Requirements
- R1: While `rst` is high at a `clk` edge, every input latch and DAC latch is cleared to zero, so each `*_code` output reads 0 and each `*_comp` output reads all ones.
- R2: In dual mode (`mode_dual`=1), a rising edge on `pN_wr` loads `pN_data` into the input latch of channel N. The DAC output of that channel does not change from this alone.
- R3: In dual mode, a rising edge on `pN_ck` copies the input latch of channel N into its DAC latch. When `pN_wr` and `pN_ck` rise in the same cycle, the DAC latch receives the input latch value from before that write.
- R4: In dual mode, the strobes of one channel never change the input latch or DAC latch of the other channel.
- R5: Codes are straight binary. Each `*_comp` output equals 2^W-1 minus its `*_code` output, so an all-ones code gives a complement of zero.
- R6: In interleaved mode (`mode_dual`=0), a rising edge on `iq_wr` loads `p1_data` into the channel-1 input latch when `iq_sel` is 1, and into the channel-2 input latch when `iq_sel` is 0.
- R7: In interleaved mode, the DAC latches update only on every second rising edge of `iq_ck`. After the divider has been cleared, the first edge does not update them and the second edge does. Both DAC latches always update on the same edge.
- R8: While `iq_rst` is high, or while the block is in dual mode, the divider is held cleared and no interleaved update takes place, even if `iq_ck` rises in that cycle.
- R9: In dual mode, `iq_wr`, `iq_ck`, `iq_sel` and `iq_rst` have no effect on any latch. In interleaved mode, `p1_wr`, `p1_ck`, `p2_data`, `p2_wr` and `p2_ck` have no effect on any latch.
- R10: Actions fire only on a low-to-high change of a strobe. Holding a strobe high does not repeat the action, even if the data changes while the strobe stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all strobes |
| rst | input | 1 | Synchronous active-high reset of all latches |
| mode_dual | input | 1 | 1 = two independent channels, 0 = interleaved single port |
| p1_data | input | W | Channel-1 sample word. In interleaved mode it carries both channels |
| p1_wr | input | 1 | Channel-1 write strobe (dual mode) |
| p1_ck | input | 1 | Channel-1 DAC update clock (dual mode) |
| p2_data | input | W | Channel-2 sample word (dual mode) |
| p2_wr | input | 1 | Channel-2 write strobe (dual mode) |
| p2_ck | input | 1 | Channel-2 DAC update clock (dual mode) |
| iq_wr | input | 1 | Interleaved write strobe |
| iq_ck | input | 1 | Interleaved clock. Halved to update both DAC latches |
| iq_sel | input | 1 | Interleaved steering: 1 = channel 1, 0 = channel 2 |
| iq_rst | input | 1 | Clears the divide-by-two stage |
| dac1_code | output | W | Channel-1 DAC latch contents |
| dac1_comp | output | W | Complement share of channel 1 |
| dac2_code | output | W | Channel-2 DAC latch contents |
| dac2_comp | output | W | Complement share of channel 2 |

## Verification
The dual path is tested in three ways: a write followed by a separate update, a write and an update in the same cycle, and a write strobe held high while the data changes. These patterns separate a correct double buffer from a single latch, from a path that forwards the new word, and from a level-sensitive load. The interleaved path is tested by writing alternate select values between single `iq_ck` pulses. This shows whether the divider updates on the right edge, and whether words reach the right channel. Pulses on the divider reset, including one that coincides with a clock edge, pin down the divider phase. In each mode the inputs of the other mode are toggled, then an update is forced, which shows that those inputs left every latch unchanged. All-ones and all-zeros codes check the complement outputs at both ends of the range.

// File: rtl/dfe_pkg.sv
package dfe_pkg;

    typedef enum logic {
        OP_IQ   = 1'b0,
        OP_DUAL = 1'b1
    } op_mode_e;

    // per-lane control decoded for one system clock cycle
    typedef struct packed {
        logic load;     // capture a word into the input latch
        logic xfer;     // move the input latch into the DAC latch
        logic from_p1;  // take the word from the shared port
    } lane_ctl_t;

    localparam int unsigned N_LANES = 2;

    function automatic bit width_ok(input int unsigned w);
        return (w == 10) || (w == 12) || (w == 14);
    endfunction

    function automatic lane_ctl_t lane_ctl(
        input op_mode_e m,
        input logic     own_wr_rise,
        input logic     own_ck_rise,
        input logic     iq_wr_rise,
        input logic     sel_hit,
        input logic     half_fire
    );
        lane_ctl_t c;
        if (m == OP_DUAL) begin
            c.load    = own_wr_rise;
            c.xfer    = own_ck_rise;
            c.from_p1 = 1'b0;
        end else begin
            c.load    = iq_wr_rise & sel_hit;
            c.xfer    = half_fire;
            c.from_p1 = 1'b1;
        end
        return c;
    endfunction

endpackage

// File: rtl/dfe_rise.sv
module dfe_rise #(
    parameter int unsigned N = 6
) (
    input  logic         clk,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] lvl_q;

    // history tracks the pins in every cycle, reset or not
    always_ff @(posedge clk) begin
        lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/dfe_half.sv
module dfe_half (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    output logic fire
);
    logic phase;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase <= 1'b0;
        end else if (tick) begin
            phase <= ~phase;
        end
    end

    assign fire = tick & phase & ~clr;
endmodule

// File: rtl/dfe_lane.sv
module dfe_lane #(
    parameter int unsigned W = 14
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         xfer,
    input  logic [W-1:0] din,
    output logic [W-1:0] dac_q
);
    logic [W-1:0] in_q;

    // master/slave: a transfer in the same cycle as a load takes the old word
    always_ff @(posedge clk) begin
        if (rst) begin
            in_q  <= '0;
            dac_q <= '0;
        end else begin
            if (load) in_q  <= din;
            if (xfer) dac_q <= in_q;
        end
    end
endmodule

// File: rtl/dac_front.sv
module dac_front
    import dfe_pkg::*;
#(
    parameter int unsigned W = 14
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mode_dual,
    input  logic [W-1:0] p1_data,
    input  logic         p1_wr,
    input  logic         p1_ck,
    input  logic [W-1:0] p2_data,
    input  logic         p2_wr,
    input  logic         p2_ck,
    input  logic         iq_wr,
    input  logic         iq_ck,
    input  logic         iq_sel,
    input  logic         iq_rst,
    output logic [W-1:0] dac1_code,
    output logic [W-1:0] dac1_comp,
    output logic [W-1:0] dac2_code,
    output logic [W-1:0] dac2_comp
);
    localparam int unsigned N_STB = 2 * N_LANES + 2;
    localparam int unsigned S_IQWR = 2 * N_LANES;
    localparam int unsigned S_IQCK = 2 * N_LANES + 1;

    generate
        if (!width_ok(W)) begin : g_bad_width
            $error("dac_front: unsupported sample width");
        end
    endgenerate

    op_mode_e mode;
    assign mode = op_mode_e'(mode_dual);

    // strobe order: lane0 wr, lane0 ck, lane1 wr, lane1 ck, iq wr, iq ck
    logic [N_STB-1:0] stb_lvl, stb_rise;
    assign stb_lvl = {iq_ck, iq_wr, p2_ck, p2_wr, p1_ck, p1_wr};

    dfe_rise #(.N(N_STB)) u_rise (
        .clk  (clk),
        .lvl  (stb_lvl),
        .rise (stb_rise)
    );

    logic half_fire;
    dfe_half u_half (
        .clk  (clk),
        .rst  (rst),
        .clr  (iq_rst | mode_dual),
        .tick (stb_rise[S_IQCK]),
        .fire (half_fire)
    );

    logic [W-1:0] port_d [N_LANES];
    logic [W-1:0] dac_q  [N_LANES];
    assign port_d[0] = p1_data;
    assign port_d[1] = p2_data;

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        lane_ctl_t    ctl;
        logic         sel_hit;
        logic [W-1:0] din;

        assign sel_hit = (i == 0) ? iq_sel : ~iq_sel;
        assign ctl = lane_ctl(mode, stb_rise[2*i], stb_rise[2*i+1],
                              stb_rise[S_IQWR], sel_hit, half_fire);
        assign din = ctl.from_p1 ? p1_data : port_d[i];

        dfe_lane #(.W(W)) u_lane (
            .clk   (clk),
            .rst   (rst),
            .load  (ctl.load),
            .xfer  (ctl.xfer),
            .din   (din),
            .dac_q (dac_q[i])
        );
    end

    assign dac1_code = dac_q[0];
    assign dac2_code = dac_q[1];
    assign dac1_comp = ~dac_q[0];
    assign dac2_comp = ~dac_q[1];
endmodule

// File: rtl/dac_front_chk.sv
module dac_front_chk #(
    parameter int unsigned W = 14
) (
    input logic         clk,
    input logic         rst,
    input logic         mode_dual,
    input logic         p1_ck,
    input logic         p2_ck,
    input logic         iq_ck,
    input logic         iq_rst,
    input logic [W-1:0] dac1_code,
    input logic [W-1:0] dac2_code
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (dac1_code == '0 && dac2_code == '0));

    p_dac1_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (mode_dual && !$rose(p1_ck)) |=> $stable(dac1_code));

    p_dac2_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (mode_dual && !$rose(p2_ck)) |=> $stable(dac2_code));

    p_iq_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!mode_dual && !$rose(iq_ck)) |=> ($stable(dac1_code) && $stable(dac2_code)));

    p_divrst_block_r8: assert property (@(posedge clk) disable iff (rst)
        (!mode_dual && iq_rst) |=> ($stable(dac1_code) && $stable(dac2_code)));
endmodule

bind dac_front dac_front_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_dual (mode_dual),
    .p1_ck     (p1_ck),
    .p2_ck     (p2_ck),
    .iq_ck     (iq_ck),
    .iq_rst    (iq_rst),
    .dac1_code (dac1_code),
    .dac2_code (dac2_code)
);

// File: tb/dac_front_test.sv
module dac_front_test;
    localparam int W = 14;
    localparam time CLK_PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         mode_dual = 1'b1;
    logic [W-1:0] p1_data = '0, p2_data = '0;
    logic         p1_wr = 0, p1_ck = 0, p2_wr = 0, p2_ck = 0;
    logic         iq_wr = 0, iq_ck = 0, iq_sel = 0, iq_rst = 0;
    logic [W-1:0] dac1_code, dac1_comp, dac2_code, dac2_comp;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dac_front #(.W(W)) uut (
        .clk(clk), .rst(rst), .mode_dual(mode_dual),
        .p1_data(p1_data), .p1_wr(p1_wr), .p1_ck(p1_ck),
        .p2_data(p2_data), .p2_wr(p2_wr), .p2_ck(p2_ck),
        .iq_wr(iq_wr), .iq_ck(iq_ck), .iq_sel(iq_sel), .iq_rst(iq_rst),
        .dac1_code(dac1_code), .dac1_comp(dac1_comp),
        .dac2_code(dac2_code), .dac2_comp(dac2_comp)
    );

    task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // each pulse is high across exactly one rising clk edge
    task automatic wr1(input logic [W-1:0] d);
        @(negedge clk) p1_data = d; p1_wr = 1;
        @(negedge clk) p1_wr = 0;
    endtask
    task automatic ck1();
        @(negedge clk) p1_ck = 1;
        @(negedge clk) p1_ck = 0;
    endtask
    task automatic wr2(input logic [W-1:0] d);
        @(negedge clk) p2_data = d; p2_wr = 1;
        @(negedge clk) p2_wr = 0;
    endtask
    task automatic ck2();
        @(negedge clk) p2_ck = 1;
        @(negedge clk) p2_ck = 0;
    endtask
    task automatic iqw(input logic sel, input logic [W-1:0] d);
        @(negedge clk) p1_data = d; iq_sel = sel; iq_wr = 1;
        @(negedge clk) iq_wr = 0;
    endtask
    task automatic iqc();
        @(negedge clk) iq_ck = 1;
        @(negedge clk) iq_ck = 0;
    endtask
    task automatic iqr();
        @(negedge clk) iq_rst = 1;
        @(negedge clk) iq_rst = 0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 dac1 code", dac1_code, '0);
        chk("R1 dac2 code", dac2_code, '0);
        chk("R1 dac1 comp", dac1_comp, '1);
        chk("R1 dac2 comp", dac2_comp, '1);
        rst = 0;
    endtask

    task automatic t_dual_basic();
        wr1(14'h1234);
        chk("R2 no output before update", dac1_code, '0);
        ck1();
        chk("R3 update ch1", dac1_code, 14'h1234);
        chk("R4 ch2 untouched", dac2_code, '0);
        wr2(14'h0abc);
        ck2();
        chk("R2 ch2 load and update", dac2_code, 14'h0abc);
        chk("R4 ch1 untouched", dac1_code, 14'h1234);
    endtask

    task automatic t_dual_same_edge();
        @(negedge clk) p1_data = 14'h0555; p1_wr = 1; p1_ck = 1;
        @(negedge clk) p1_wr = 0; p1_ck = 0;
        chk("R3 same-edge takes old word", dac1_code, 14'h1234);
        ck1();
        chk("R3 next update takes new word", dac1_code, 14'h0555);
    endtask

    task automatic t_full_scale();
        wr1('1);
        ck1();
        chk("R5 full scale code", dac1_code, '1);
        chk("R5 full scale comp", dac1_comp, '0);
        wr1(14'h0f00);
        ck1();
        chk("R5 mid comp", dac1_comp, 14'h30ff);
        wr1('0);
        ck1();
        chk("R5 zero comp", dac1_comp, '1);
    endtask

    task automatic t_level_hold();
        @(negedge clk) p1_data = 14'h0111; p1_wr = 1;
        @(negedge clk) p1_data = 14'h0222;
        @(negedge clk) p1_wr = 0;
        ck1();
        chk("R10 held strobe loads once", dac1_code, 14'h0111);
    endtask

    task automatic t_dual_ignores_iq();
        iqw(1'b1, 14'h0777);
        iqw(1'b0, 14'h0778);
        iqc(); iqc(); iqr(); iqc(); iqc();
        chk("R9 dual ignores iq ch1", dac1_code, 14'h0111);
        chk("R9 dual ignores iq ch2", dac2_code, 14'h0abc);
        ck1(); ck2();
        chk("R9 ch1 latch untouched", dac1_code, 14'h0111);
        chk("R9 ch2 latch untouched", dac2_code, 14'h0abc);
    endtask

    task automatic t_iq_basic();
        @(negedge clk) mode_dual = 0;
        iqw(1'b1, 14'h0aaa);
        iqw(1'b0, 14'h0bbb);
        chk("R6 write alone no update", dac1_code, 14'h0111);
        iqc();
        chk("R7 first edge no update ch1", dac1_code, 14'h0111);
        chk("R7 first edge no update ch2", dac2_code, 14'h0abc);
        iqc();
        chk("R6 sel=1 to ch1", dac1_code, 14'h0aaa);
        chk("R6 sel=0 to ch2", dac2_code, 14'h0bbb);
        iqw(1'b1, 14'h0ccc);
        iqc();
        chk("R7 third edge no update", dac1_code, 14'h0aaa);
        iqc();
        chk("R7 fourth edge updates ch1", dac1_code, 14'h0ccc);
        chk("R7 fourth edge keeps ch2", dac2_code, 14'h0bbb);
    endtask

    task automatic t_iq_divider_reset();
        iqc();
        iqw(1'b1, 14'h0ddd);
        iqr();
        iqc();
        chk("R8 edge after clear no update", dac1_code, 14'h0ccc);
        iqc();
        chk("R8 second edge after clear", dac1_code, 14'h0ddd);
        iqc();
        iqw(1'b1, 14'h0eee);
        @(negedge clk) iq_rst = 1; iq_ck = 1;
        @(negedge clk) iq_rst = 0; iq_ck = 0;
        chk("R8 clear beats clock edge", dac1_code, 14'h0ddd);
        iqc();
        chk("R8 first edge after clear", dac1_code, 14'h0ddd);
        iqc();
        chk("R8 update after clear", dac1_code, 14'h0eee);
    endtask

    task automatic t_iq_ignores_ports();
        wr2(14'h0f0f);
        ck2();
        @(negedge clk) p1_data = 14'h0123; p1_wr = 1; p1_ck = 1;
        @(negedge clk) p1_wr = 0; p1_ck = 0;
        chk("R9 iq ignores p2 strobes", dac2_code, 14'h0bbb);
        chk("R9 iq ignores p1 strobes", dac1_code, 14'h0eee);
        iqc(); iqc();
        chk("R9 ch2 latch untouched in iq", dac2_code, 14'h0bbb);
        chk("R9 ch1 latch untouched in iq", dac1_code, 14'h0eee);
    endtask

    initial begin
        t_reset();
        t_dual_basic();
        t_dual_same_edge();
        t_full_scale();
        t_level_hold();
        t_dual_ignores_iq();
        t_iq_basic();
        t_iq_divider_reset();
        t_iq_ignores_ports();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule